// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two parallel data buses, called side A and side B, and keeps one storage register per side. Each register samples its own side whenever that side's capture strobe goes from 0 to 1. At most one side is driven at a time, chosen by an active-low global enable and a direction bit. The driven side receives data from the opposite side, either as live pass-through data or as the value held in the opposite side's register. A select bit per direction picks between the two, and the choice takes effect combinationally.

Capturing does not depend on the output controls. A side can be stored while both sides are isolated, and also while that side is being driven. In the second case the register takes the value that the block itself puts on the bus. Each bidirectional pin appears as three separate vectors: input, output and output-enable. Every path copies data unchanged, with no inversion. All logic runs on one clock. The reset is asynchronous and active-low, and its release is expected to be synchronous to `clk`.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage registers and both strobe histories clear to zero. After reset, a stored-data transfer in either direction outputs 8'h00.
- R2: When `a_cap` is sampled 1 at a clock edge after being sampled 0 at the edge before, the A register loads the resolved A bus value. When `b_cap` does the same, the B register loads the resolved B bus value. A stored-data transfer shows the new value starting with the next cycle.
- R3: A strobe that stays at 1 over several edges loads its register only once, on the first edge. Later changes on that bus are not stored.
- R4: With `oe_n` = 1, both `a_oe` and `b_oe` are all zeros and both `a_out` and `b_out` are all zeros, whatever the values of `dir_b` and the selects.
- R5: With `oe_n` = 0 and `dir_b` = 0, `a_oe` is all ones and `b_oe` is all zeros. `a_out` equals `b_in` when `sel_b_reg` = 0 and equals the B register when `sel_b_reg` = 1. `sel_a_reg` has no effect in this mode.
- R6: With `oe_n` = 0 and `dir_b` = 1, `b_oe` is all ones and `a_oe` is all zeros. `b_out` equals `a_in` when `sel_a_reg` = 0 and equals the A register when `sel_a_reg` = 1. `sel_b_reg` has no effect in this mode.
- R7: Changing a select bit changes the driven output within the same cycle, with no clock edge needed.
- R8: A strobe edge loads its register while `oe_n` = 1, so data can be captured with both sides isolated.
- R9: A side that is being driven captures its driven output value, not its input vector.
- R10: `a_oe` and `b_oe` are never nonzero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Global output enable, active low |
| dir_b | input | 1 | Direction: 0 drives side A, 1 drives side B |
| sel_a_reg | input | 1 | When B is driven: 0 sends live A, 1 sends the A register |
| sel_b_reg | input | 1 | When A is driven: 0 sends live B, 1 sends the B register |
| a_cap | input | 1 | Capture strobe for the A register (rising edge) |
| b_cap | input | 1 | Capture strobe for the B register (rising edge) |
| a_in | input | WIDTH | Value seen on the A pins from outside |
| a_out | output | WIDTH | Value driven onto the A pins |
| a_oe | output | WIDTH | Per-bit drive enable for the A pins |
| b_in | input | WIDTH | Value seen on the B pins from outside |
| b_out | output | WIDTH | Value driven onto the B pins |
| b_oe | output | WIDTH | Per-bit drive enable for the B pins |

## Verification
The capture and hold properties assume that both strobes are low while reset is asserted. The checker keeps no strobe history of its own, so a strobe already high at reset release would look like a held level to the hold property. The routing properties assume that inputs are steady at each sampling edge. The stimulus meets both conditions: it keeps every strobe at 0 during reset and changes all inputs only on falling clock edges. Strobes rise and fall on falling edges as well, so each load happens at a known rising edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  localparam int unsigned NUM_SIDES = 2;

  function automatic side_e far_side(input side_e s);
    return (s == SIDE_A) ? SIDE_B : SIDE_A;
  endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = strobe;
    rise   = strobe & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route #(
  parameter int WIDTH = 8
) (
  input  logic             drive,
  input  logic             use_reg,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out,
  output logic [WIDTH-1:0] oe
);

  always_comb begin
    out = '0;
    oe  = '0;
    if (drive) begin
      oe  = '1;
      out = use_reg ? stored : live;
    end
  end

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir_b,
  input  logic             sel_a_reg,
  input  logic             sel_b_reg,
  input  logic             a_cap,
  input  logic             b_cap,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  localparam int SIDES = int'(NUM_SIDES);

  logic [SIDES-1:0] cap_s;
  logic [SIDES-1:0] use_reg_s;
  logic [SIDES-1:0] drive_s;
  logic [SIDES-1:0] rise_s;
  logic [WIDTH-1:0] pin_in    [SIDES];
  logic [WIDTH-1:0] pin_out   [SIDES];
  logic [WIDTH-1:0] pin_oe    [SIDES];
  logic [WIDTH-1:0] resolved  [SIDES];
  logic [WIDTH-1:0] store_q   [SIDES];
  logic [WIDTH-1:0] a_store_q;
  logic [WIDTH-1:0] b_store_q;

  // Each side's select picks the opposite side's register for its own output.
  assign cap_s     = {b_cap, a_cap};
  assign use_reg_s = {sel_a_reg, sel_b_reg};
  assign pin_in[SIDE_A] = a_in;
  assign pin_in[SIDE_B] = b_in;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam side_e HERE = side_e'(s);
    localparam side_e FAR  = far_side(HERE);

    assign drive_s[s] = ~oe_n & (dir_b == logic'(HERE));

    xcvr_route #(.WIDTH(WIDTH)) u_route (
      .drive   (drive_s[s]),
      .use_reg (use_reg_s[s]),
      .live    (pin_in[FAR]),
      .stored  (store_q[FAR]),
      .out     (pin_out[s]),
      .oe      (pin_oe[s])
    );

    // Bus level per bit: driven value where this block drives, pin input elsewhere.
    always_comb begin
      resolved[s] = (pin_out[s] & pin_oe[s]) | (pin_in[s] & ~pin_oe[s]);
    end

    xcvr_strobe_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (cap_s[s]),
      .rise   (rise_s[s])
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rise_s[s]),
      .d     (resolved[s]),
      .q     (store_q[s])
    );
  end

  assign a_out     = pin_out[SIDE_A];
  assign a_oe      = pin_oe[SIDE_A];
  assign b_out     = pin_out[SIDE_B];
  assign b_oe      = pin_oe[SIDE_B];
  assign a_store_q = store_q[SIDE_A];
  assign b_store_q = store_q[SIDE_B];

endmodule

// File: rtl/dual_bus_xcvr_chk.sv
module dual_bus_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             dir_b,
  input logic             sel_a_reg,
  input logic             sel_b_reg,
  input logic             a_cap,
  input logic             b_cap,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic [WIDTH-1:0] b_oe,
  input logic [WIDTH-1:0] a_store,
  input logic [WIDTH-1:0] b_store
);

  logic [WIDTH-1:0] a_bus;
  logic [WIDTH-1:0] b_bus;

  always_comb begin
    a_bus = (a_out & a_oe) | (a_in & ~a_oe);
    b_bus = (b_out & b_oe) | (b_in & ~b_oe);
  end

  a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));

  a_r4_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

  a_r5_live: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !dir_b && !sel_b_reg) |-> (a_oe == '1 && a_out == b_in));

  a_r5_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !dir_b && sel_b_reg) |-> (a_oe == '1 && a_out == b_store));

  a_r6_live: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir_b && !sel_a_reg) |-> (b_oe == '1 && b_out == a_in));

  a_r6_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir_b && sel_a_reg) |-> (b_oe == '1 && b_out == a_store));

  a_r2_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cap && !$past(a_cap)) |=> (a_store == $past(a_bus)));

  a_r2_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_cap && !$past(b_cap)) |=> (b_store == $past(b_bus)));

  a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_cap && !$past(a_cap)) |=> $stable(a_store));

  a_r3_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_cap && !$past(b_cap)) |=> $stable(b_store));

endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_n      (oe_n),
  .dir_b     (dir_b),
  .sel_a_reg (sel_a_reg),
  .sel_b_reg (sel_b_reg),
  .a_cap     (a_cap),
  .b_cap     (b_cap),
  .a_in      (a_in),
  .a_out     (a_out),
  .a_oe      (a_oe),
  .b_in      (b_in),
  .b_out     (b_out),
  .b_oe      (b_oe),
  .a_store   (a_store_q),
  .b_store   (b_store_q)
);

// File: tb/test_dual_bus_xcvr.sv
module test_dual_bus_xcvr;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         oe_n, dir_b, sel_a_reg, sel_b_reg, a_cap, b_cap;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_bus_xcvr #(.WIDTH(W)) i_dual_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir_b(dir_b),
    .sel_a_reg(sel_a_reg), .sel_b_reg(sel_b_reg),
    .a_cap(a_cap), .b_cap(b_cap),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct packed {
    logic         oe_n;
    logic         dir_b;
    logic         sel_a;
    logic         sel_b;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic         a_drv;
    logic [W-1:0] a_exp;
    logic         b_drv;
    logic [W-1:0] b_exp;
  } vec_t;

  // Registers hold A=3C, B=A5 while this table runs.
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h33, 8'h44, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h99, 8'h5A, 1'b1, 8'h5A, 1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h99, 8'h5A, 1'b1, 8'hA5, 1'b0, 8'h00},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, 8'h66, 1'b0, 8'h00, 1'b1, 8'hC3},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'hC3, 8'h66, 1'b0, 8'h00, 1'b1, 8'h3C},
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 8'hFF, 1'b1, 8'hFF, 1'b0, 8'h00},
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h80, 1'b0, 8'h00, 1'b1, 8'h00}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic mode(input logic n, input logic d, input logic sa, input logic sb);
    oe_n = n; dir_b = d; sel_a_reg = sa; sel_b_reg = sb;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode(1'b1, 1'b0, 1'b0, 1'b0);
    a_cap = 1'b0; b_cap = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Reset state: isolated, both registers zero (R1, R4)
    #1 check("R4 reset a_oe", a_oe, '0);
    check("R4 reset b_oe", b_oe, '0);
    mode(1'b0, 1'b0, 1'b0, 1'b1); b_in = 8'hEE;
    #1 check("R1 stored B after reset", a_out, 8'h00);
    mode(1'b0, 1'b1, 1'b1, 1'b0); a_in = 8'hDD;
    #1 check("R1 stored A after reset", b_out, 8'h00);

    // R8: capture both sides while isolated
    @(negedge clk);
    mode(1'b1, 1'b0, 1'b0, 1'b0);
    a_in = 8'h3C; b_in = 8'hA5; a_cap = 1'b1; b_cap = 1'b1;
    @(negedge clk);
    a_cap = 1'b0; b_cap = 1'b0;

    // Table walk: R4, R5, R6, R8
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mode(VEC[i].oe_n, VEC[i].dir_b, VEC[i].sel_a, VEC[i].sel_b);
      a_in = VEC[i].a_in; b_in = VEC[i].b_in;
      #1;
      check("R5/R4 table a_oe",  a_oe,  VEC[i].a_drv ? '1 : '0);
      check("R5/R8 table a_out", a_out, VEC[i].a_exp);
      check("R6/R4 table b_oe",  b_oe,  VEC[i].b_drv ? '1 : '0);
      check("R6/R8 table b_out", b_out, VEC[i].b_exp);
      check("R10 table exclusive", W'((|a_oe) & (|b_oe)), '0);
    end

    // R7: select flips output within one cycle
    @(negedge clk);
    mode(1'b0, 1'b0, 1'b0, 1'b0); b_in = 8'h42;
    #1 check("R7 live before flip", a_out, 8'h42);
    sel_b_reg = 1'b1;
    #1 check("R7 stored after flip", a_out, 8'hA5);
    mode(1'b0, 1'b1, 1'b0, 1'b0); a_in = 8'h24;
    #1 check("R7 live B side", b_out, 8'h24);
    sel_a_reg = 1'b1;
    #1 check("R7 stored B side", b_out, 8'h3C);

    // R3: held strobe loads once
    @(negedge clk);
    mode(1'b1, 1'b0, 1'b0, 1'b0); a_in = 8'h77; a_cap = 1'b1;
    @(negedge clk) a_in = 8'h88;
    @(negedge clk) a_in = 8'h99; a_cap = 1'b0;
    @(negedge clk);
    mode(1'b0, 1'b1, 1'b1, 1'b0);
    #1 check("R3 held strobe kept first value", b_out, 8'h77);

    // R2: a fresh rising edge loads again, visible next cycle
    @(negedge clk);
    mode(1'b1, 1'b0, 1'b0, 1'b0); a_in = 8'h99; a_cap = 1'b1;
    @(negedge clk) a_cap = 1'b0;
    mode(1'b0, 1'b1, 1'b1, 1'b0);
    #1 check("R2 A register reloaded", b_out, 8'h99);
    @(negedge clk);
    mode(1'b1, 1'b0, 1'b0, 1'b0); b_in = 8'h5C; b_cap = 1'b1;
    @(negedge clk) b_cap = 1'b0;
    mode(1'b0, 1'b0, 1'b0, 1'b1);
    #1 check("R2 B register reloaded", a_out, 8'h5C);

    // R9: driven side stores its driven value
    @(negedge clk);
    mode(1'b0, 1'b0, 1'b0, 1'b0); b_in = 8'h6E; a_in = 8'h11; a_cap = 1'b1;
    @(negedge clk) a_cap = 1'b0;
    mode(1'b0, 1'b1, 1'b1, 1'b0);
    #1 check("R9 A stores driven value", b_out, 8'h6E);
    @(negedge clk);
    mode(1'b0, 1'b1, 1'b0, 1'b0); a_in = 8'hD2; b_in = 8'h00; b_cap = 1'b1;
    @(negedge clk) b_cap = 1'b0;
    mode(1'b0, 1'b0, 1'b0, 1'b1);
    #1 check("R9 B stores driven value", a_out, 8'hD2);

    // R1: reset in the middle of a run clears loaded registers
    @(negedge clk) rst_n = 1'b0;
    mode(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    mode(1'b0, 1'b0, 1'b0, 1'b1);
    #1 check("R1 B register cleared", a_out, 8'h00);
    mode(1'b0, 1'b1, 1'b1, 1'b0);
    #1 check("R1 A register cleared", b_out, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule